// File: doc/BRIEF.md
# SMBus Indexed Block Register Slave

This block is a two-wire bus slave that exposes a bank of 8-bit configuration registers to a bus host. The host picks a register with a starting index and moves a block of bytes in one transfer. Each byte moved advances the index by one. SCL and SDA arrive as plain inputs and are oversampled on the system clock. The block answers by pulling SDA low through an open-drain enable. The whole register bank is available as one flat parallel image for the logic around it.

The host writes by sending the write address, a starting index, a byte count and then that many data bytes. The host reads in two steps. It first sends the write address and a starting index. It then issues a repeated START followed by the read address. The slave answers with a count byte and then the registers in index order. The length of a read is set by a programmable count register, not by the request. The host acknowledges every byte except the last one, which it refuses before issuing STOP.

Top module: `smb_regbank_slave`

## Requirements
- R1: After reset, SDA is released (sda_oe = 0). Register 8 (the count register) holds 0x0F, register 7 (the identity register) holds 0x01, and every other register holds 0x00.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. After a START, the address byte 0xD2 (write) or 0xD3 (read) is acknowledged by pulling SDA low during the ninth clock.
- R3: Any other address byte is not acknowledged. SDA then stays released and no register changes until the next START.
- R4: In a write, the byte after the address is the starting index N and the next byte is the count X. The following X data bytes are each acknowledged and stored in registers N to N+X-1. At most one register changes per clock.
- R5: Data bytes beyond the count X in a write are not acknowledged and are not stored.
- R6: After a repeated START with address 0xD3, the slave sends the value of the count register first. It then sends registers from the last written index upward, each byte MSB first.
- R7: Once the slave has sent as many data bytes as the count register holds, further bytes read as 0xFF because SDA stays released.
- R8: Writes never change register 7. Writes never change bits 5:4 of register 9; its other bits take the written value.
- R9: A write to an index at or beyond NUM_REGS is acknowledged and discarded. A read at such an index returns 0x00.
- R10: A STOP or a new START at any point ends the transfer. Bytes already stored are kept, and a partly received byte is never stored.
- R11: The slave raises its SDA drive only while SCL is low. It releases SDA after its ACK slot and after the host refuses a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_image | output | NUM_REGS*8 | All registers, register i in bits i*8+7 down to i*8 |

## Verification
The bench probes how the write count limits storage. A slave that ignores the count would acknowledge and store an extra byte in register 6. It also reads past the count-register length, where a wrong design would keep driving register contents instead of 0xFF. Both the index carried across a repeated START and the count byte that opens every read are checked byte by byte. A design that reset the index on START would return the wrong registers. Aborts by STOP in the middle of a byte, and by START after the count byte, are checked to leave earlier bytes in place and never store a partial byte. A foreign address, read-only bits, and indices past the end of the bank are each checked at the register image.

// File: rtl/smb_regbank_pkg.sv
package smb_regbank_pkg;

    localparam logic [6:0] DEV_ADDR_DEFAULT = 7'h69;
    localparam int         IDX_IDENT        = 7;
    localparam int         IDX_COUNT        = 8;
    localparam int         IDX_WDOG         = 9;
    localparam logic [7:0] IDENT_VALUE      = 8'h01;
    localparam logic [7:0] COUNT_DEFAULT    = 8'h0F;
    localparam logic [7:0] WDOG_RO_MASK     = 8'h30;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_INDEX,
        PH_COUNT,
        PH_WDATA,
        PH_RDATA,
        PH_IGNORE
    } phase_e;

    // Bus events derived from the synchronised lines, one clock wide.
    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } line_ev_t;

    typedef struct packed {
        logic       en;
        logic [7:0] idx;
        logic [7:0] data;
    } reg_wr_t;

    function automatic logic [7:0] reset_value(input int idx);
        case (idx)
            IDX_IDENT: return IDENT_VALUE;
            IDX_COUNT: return COUNT_DEFAULT;
            default:   return 8'h00;
        endcase
    endfunction

    // Bits set to 1 accept writes from the bus.
    function automatic logic [7:0] write_mask(input int idx);
        case (idx)
            IDX_IDENT: return 8'h00;
            IDX_WDOG:  return ~WDOG_RO_MASK;
            default:   return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync
    import smb_regbank_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output line_ev_t ev
);
    logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_q, sda_q;
    logic scl_s, sda_s;

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    // Idle bus is high, so the pipes reset to ones.
    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_in};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    always_comb begin
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
        ev.sda      = sda_s;
    end
endmodule

// File: rtl/smb_reg_file.sv
module smb_reg_file
    import smb_regbank_pkg::*;
#(
    parameter int NUM_REGS = 21
) (
    input  logic                  clk,
    input  logic                  rst,
    input  reg_wr_t               wr,
    input  logic [7:0]            rd_idx,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] image
);
    logic [7:0] regs [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [7:0] WMASK = write_mask(i);
        localparam logic [7:0] RVAL  = reset_value(i);

        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= RVAL;
            else if (wr.en && wr.idx == 8'(i))
                regs[i] <= (regs[i] & ~WMASK) | (wr.data & WMASK);
        end

        assign image[i*8 +: 8] = regs[i];
    end

    // Indices past the bank read as zero.
    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_idx == 8'(i)) rd_data = regs[i];
    end
endmodule

// File: rtl/smb_xfer_engine.sv
module smb_xfer_engine
    import smb_regbank_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = DEV_ADDR_DEFAULT
) (
    input  logic       clk,
    input  logic       rst,
    input  line_ev_t   ev,
    input  logic [7:0] rd_data,
    input  logic [7:0] count_val,
    output reg_wr_t    wr,
    output logic [7:0] rd_idx,
    output logic       sda_oe
);
    phase_e     phase;
    logic       ack_slot;
    logic       mack;
    logic [3:0] bit_cnt;
    logic [7:0] shreg, txsh, ptr, remain;
    logic       hit_w, hit_r;
    logic [7:0] next_tx;

    assign hit_w   = (shreg == {DEV_ADDR, 1'b0});
    assign hit_r   = (shreg == {DEV_ADDR, 1'b1});
    assign next_tx = (remain != 8'd0) ? rd_data : 8'hFF;
    assign rd_idx  = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            ack_slot <= 1'b0;
            mack     <= 1'b0;
            bit_cnt  <= 4'd0;
            shreg    <= 8'h00;
            txsh     <= 8'h00;
            ptr      <= 8'h00;
            remain   <= 8'h00;
            sda_oe   <= 1'b0;
            wr       <= '0;
        end else begin
            wr.en <= 1'b0;
            if (ev.stop) begin
                phase    <= PH_IDLE;
                ack_slot <= 1'b0;
                bit_cnt  <= 4'd0;
                sda_oe   <= 1'b0;
            end else if (ev.start) begin
                phase    <= PH_ADDR;
                ack_slot <= 1'b0;
                bit_cnt  <= 4'd0;
                sda_oe   <= 1'b0;
            end else begin
                case (phase)
                    PH_ADDR, PH_INDEX, PH_COUNT, PH_WDATA: begin
                        if (ev.scl_rise && !ack_slot && bit_cnt != 4'd8) begin
                            shreg   <= {shreg[6:0], ev.sda};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (ev.scl_fall && !ack_slot && bit_cnt == 4'd8) begin
                            // Whole byte in: decide the ACK, commit writes.
                            ack_slot <= 1'b1;
                            case (phase)
                                PH_ADDR: begin
                                    if (hit_w || hit_r) begin
                                        sda_oe <= 1'b1;
                                    end else begin
                                        phase    <= PH_IGNORE;
                                        ack_slot <= 1'b0;
                                    end
                                end
                                PH_INDEX: begin
                                    ptr    <= shreg;
                                    sda_oe <= 1'b1;
                                end
                                PH_COUNT: begin
                                    remain <= shreg;
                                    sda_oe <= 1'b1;
                                end
                                default: begin
                                    if (remain != 8'd0) begin
                                        sda_oe <= 1'b1;
                                        wr     <= '{en: 1'b1, idx: ptr, data: shreg};
                                        ptr    <= ptr + 8'd1;
                                        remain <= remain - 8'd1;
                                    end
                                end
                            endcase
                        end else if (ev.scl_fall && ack_slot) begin
                            ack_slot <= 1'b0;
                            bit_cnt  <= 4'd0;
                            sda_oe   <= 1'b0;
                            case (phase)
                                PH_ADDR: begin
                                    if (shreg[0]) begin
                                        phase  <= PH_RDATA;
                                        txsh   <= count_val;
                                        remain <= count_val;
                                        sda_oe <= ~count_val[7];
                                    end else begin
                                        phase <= PH_INDEX;
                                    end
                                end
                                PH_INDEX: phase <= PH_COUNT;
                                PH_COUNT: phase <= PH_WDATA;
                                default:  ;
                            endcase
                        end
                    end
                    PH_RDATA: begin
                        if (ev.scl_fall && bit_cnt != 4'd8) begin
                            bit_cnt <= bit_cnt + 4'd1;
                            txsh    <= {txsh[6:0], 1'b0};
                            sda_oe  <= (bit_cnt == 4'd7) ? 1'b0 : ~txsh[6];
                        end else if (ev.scl_rise && bit_cnt == 4'd8) begin
                            mack <= ~ev.sda;
                        end else if (ev.scl_fall && bit_cnt == 4'd8) begin
                            if (mack) begin
                                bit_cnt <= 4'd0;
                                txsh    <= next_tx;
                                sda_oe  <= ~next_tx[7];
                                if (remain != 8'd0) begin
                                    ptr    <= ptr + 8'd1;
                                    remain <= remain - 8'd1;
                                end
                            end else begin
                                phase <= PH_IGNORE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/smb_regbank_slave.sv
module smb_regbank_slave
    import smb_regbank_pkg::*;
#(
    parameter int         NUM_REGS    = 21,
    parameter logic [6:0] DEV_ADDR    = DEV_ADDR_DEFAULT,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_in,
    input  logic                  sda_in,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] reg_image
);
    line_ev_t   ev;
    reg_wr_t    wr;
    logic [7:0] rd_idx, rd_data;
    logic [7:0] count_val;

    assign count_val = reg_image[IDX_COUNT*8 +: 8];

    smb_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    smb_xfer_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .rd_data   (rd_data),
        .count_val (count_val),
        .wr        (wr),
        .rd_idx    (rd_idx),
        .sda_oe    (sda_oe)
    );

    smb_reg_file #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .image   (reg_image)
    );
endmodule

// File: rtl/smb_regbank_checks.sv
module smb_regbank_checks
    import smb_regbank_pkg::*;
#(
    parameter int NUM_REGS = 21
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  scl_in,
    input logic                  sda_oe,
    input logic [NUM_REGS*8-1:0] reg_image
);
    logic [NUM_REGS*8-1:0] prev_image;
    logic [NUM_REGS-1:0]   changed;

    always_ff @(posedge clk) prev_image <= reg_image;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_chg
        assign changed[i] = (reg_image[i*8 +: 8] != prev_image[i*8 +: 8]);
    end

    a_r1_count_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> reg_image[IDX_COUNT*8 +: 8] == COUNT_DEFAULT);

    a_r8_ident_locked: assert property (@(posedge clk) disable iff (rst)
        $stable(reg_image[IDX_IDENT*8 +: 8]));

    a_r8_wdog_bits_locked: assert property (@(posedge clk) disable iff (rst)
        $stable(reg_image[IDX_WDOG*8+4 +: 2]));

    a_r11_drive_when_scl_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_in);

    a_r4_single_commit: assert property (@(posedge clk) disable iff (rst)
        $onehot0(changed));
endmodule

bind smb_regbank_slave smb_regbank_checks #(.NUM_REGS(NUM_REGS)) u_checks (
    .clk       (clk),
    .rst       (rst),
    .scl_in    (scl_in),
    .sda_oe    (sda_oe),
    .reg_image (reg_image)
);

// File: tb/smb_regbank_slave_bench.sv
module smb_regbank_slave_bench;
    localparam int NUM_REGS = 21;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_oe;
    logic [NUM_REGS*8-1:0] image;
    wire sda_line = !(sda_oe || m_low);

    always #2 clk = ~clk;

    smb_regbank_slave #(.NUM_REGS(NUM_REGS)) u_smb_regbank_slave (
        .clk       (clk),
        .rst       (rst),
        .scl_in    (scl),
        .sda_in    (sda_line),
        .sda_oe    (sda_oe),
        .reg_image (image)
    );

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] obs_q[$];

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rb(input int i);
        return image[i*8 +: 8];
    endfunction

    task automatic wait_q;
        repeat (10) @(negedge clk);
    endtask

    task automatic expect_byte(input logic [7:0] b, input string tag);
        exp_q.push_back(b);
        tag_q.push_back(tag);
    endtask

    // Scoreboard monitor: compares every byte the host reads.
    initial begin
        forever begin
            @(negedge clk);
            while (obs_q.size() > 0) begin
                logic [7:0] o;
                o = obs_q.pop_front();
                if (exp_q.size() == 0) begin
                    check(o, 32'hFFFF_FFFF, "scoreboard underflow");
                end else begin
                    check(o, exp_q.pop_front(), tag_q.pop_front());
                end
            end
        end
    end

    task automatic bus_start;
        m_low = 1'b0; scl = 1'b1; wait_q();
        m_low = 1'b1; wait_q();
        scl = 1'b0; wait_q();
    endtask

    task automatic bus_rstart;
        m_low = 1'b0; wait_q();
        scl = 1'b1; wait_q();
        m_low = 1'b1; wait_q();
        scl = 1'b0; wait_q();
    endtask

    task automatic bus_stop;
        m_low = 1'b1; wait_q();
        scl = 1'b1; wait_q();
        m_low = 1'b0; wait_q();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_low = !b[i]; wait_q();
            scl = 1'b1; wait_q(); wait_q();
            scl = 1'b0; wait_q();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        m_low = 1'b0; wait_q();
        scl = 1'b1; wait_q();
        ack = !sda_line; wait_q();
        scl = 1'b0; wait_q();
    endtask

    task automatic recv_byte(input logic give_ack);
        logic [7:0] b;
        b = 8'h00;
        m_low = 1'b0;
        for (int i = 0; i < 8; i++) begin
            wait_q();
            scl = 1'b1; wait_q();
            b = {b[6:0], sda_line}; wait_q();
            scl = 1'b0;
        end
        wait_q();
        m_low = give_ack; wait_q();
        scl = 1'b1; wait_q(); wait_q();
        scl = 1'b0; wait_q();
        m_low = 1'b0;
        obs_q.push_back(b);
    endtask

    // Write transaction: n data bytes, the first cnt of which should be ACKed.
    task automatic write_block(input logic [7:0] idx, input logic [7:0] cnt, input int n,
                               input logic [7:0] d0, input logic [7:0] d1,
                               input logic [7:0] d2, input string tag);
        logic ack;
        logic [7:0] d [3];
        d[0] = d0; d[1] = d1; d[2] = d2;
        bus_start();
        send_byte(8'hD2, ack); check(ack, 1, {tag, " R2 write address ACK"});
        send_byte(idx, ack);   check(ack, 1, {tag, " index ACK"});
        send_byte(cnt, ack);   check(ack, 1, {tag, " count ACK"});
        check(sda_oe, 0, "R11 released after ACK slot");
        for (int i = 0; i < n; i++) begin
            send_byte(d[i], ack);
            check(ack, (i < int'(cnt)) ? 1 : 0, {tag, " data ACK"});
            check(sda_oe, 0, "R11 released after ACK slot");
        end
        bus_stop();
    endtask

    task automatic read_block(input logic [7:0] idx, input int n);
        logic ack;
        bus_start();
        send_byte(8'hD2, ack); check(ack, 1, "R2 write address ACK");
        send_byte(idx, ack);   check(ack, 1, "R6 index ACK");
        bus_rstart();
        send_byte(8'hD3, ack); check(ack, 1, "R2 read address ACK");
        for (int i = 0; i < n; i++) recv_byte(i < n - 1);
        wait_q();
        check(sda_oe, 0, "R11 released after host NACK");
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic ack;
        logic [NUM_REGS*8-1:0] snap;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        wait_q();

        // R1 reset state
        check(sda_oe, 0, "R1 SDA released");
        check(rb(8), 8'h0F, "R1 count register");
        check(rb(7), 8'h01, "R1 identity register");
        check(rb(0), 8'h00, "R1 register 0");
        check(rb(9), 8'h00, "R1 register 9");

        // R4 block write
        write_block(8'd2, 8'd3, 3, 8'h11, 8'h22, 8'h33, "R4");
        check(rb(2), 8'h11, "R4 reg2");
        check(rb(3), 8'h22, "R4 reg3");
        check(rb(4), 8'h33, "R4 reg4");

        // R5 bytes past the count
        write_block(8'd5, 8'd1, 2, 8'h44, 8'h55, 8'h00, "R5");
        check(rb(5), 8'h44, "R5 reg5 stored");
        check(rb(6), 8'h00, "R5 reg6 untouched");

        // R3 foreign address
        bus_start();
        send_byte(8'hA0, ack); check(ack, 0, "R3 foreign address NACK");
        send_byte(8'h00, ack); check(ack, 0, "R3 follow-on byte NACK");
        send_byte(8'h01, ack); check(ack, 0, "R3 follow-on byte NACK");
        send_byte(8'h77, ack); check(ack, 0, "R3 follow-on byte NACK");
        bus_stop();
        check(rb(0), 8'h00, "R3 reg0 untouched");

        // R8 read-only bits
        write_block(8'd7, 8'd1, 1, 8'hAA, 8'h00, 8'h00, "R8");
        check(rb(7), 8'h01, "R8 identity unchanged");
        write_block(8'd9, 8'd1, 1, 8'hFF, 8'h00, 8'h00, "R8");
        check(rb(9), 8'hCF, "R8 status bits kept");

        // R6 R7 read with programmed length 3
        write_block(8'd8, 8'd1, 1, 8'h03, 8'h00, 8'h00, "R6");
        check(rb(8), 8'h03, "R6 count register written");
        expect_byte(8'h03, "R6 count byte");
        expect_byte(8'h11, "R6 data reg2");
        expect_byte(8'h22, "R6 data reg3");
        expect_byte(8'h33, "R6 data reg4");
        expect_byte(8'hFF, "R7 past length");
        read_block(8'd2, 5);

        // R9 out of range
        snap = image;
        write_block(8'd30, 8'd1, 1, 8'h5A, 8'h00, 8'h00, "R9");
        check(image === snap, 1, "R9 image unchanged");
        write_block(8'd20, 8'd1, 1, 8'hC3, 8'h00, 8'h00, "R9");
        check(rb(20), 8'hC3, "R9 last register");
        expect_byte(8'h03, "R9 count byte");
        expect_byte(8'hC3, "R9 reg20");
        expect_byte(8'h00, "R9 index 21 reads zero");
        expect_byte(8'h00, "R9 index 22 reads zero");
        read_block(8'd20, 4);

        // R10 STOP inside a byte
        bus_start();
        send_byte(8'hD2, ack); send_byte(8'd12, ack);
        send_byte(8'd2, ack);  send_byte(8'h5A, ack);
        check(ack, 1, "R10 first byte ACK");
        send_bits(8'hA5, 4);
        bus_stop();
        check(rb(12), 8'h5A, "R10 committed byte kept");
        check(rb(13), 8'h00, "R10 partial byte dropped");

        // R10 START after the count byte
        bus_start();
        send_byte(8'hD2, ack); send_byte(8'd14, ack); send_byte(8'd1, ack);
        bus_rstart();
        send_byte(8'hD2, ack); check(ack, 1, "R10 restart address ACK");
        send_byte(8'd15, ack); send_byte(8'd1, ack); send_byte(8'h66, ack);
        check(ack, 1, "R10 data ACK after restart");
        bus_stop();
        check(rb(14), 8'h00, "R10 aborted target untouched");
        check(rb(15), 8'h66, "R10 new transfer stored");

        wait (obs_q.size() == 0);
        repeat (4) @(negedge clk);
        check(exp_q.size(), 0, "R6 scoreboard drained");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule